// File: doc/BRIEF.md
# Dual-Mode Transmit Word Sequencer

This block sits in front of a serial line encoder. Once per reference period it captures a 32-bit or 16-bit input word together with its framing controls. It turns the capture into a stream of 16-bit words. Each word leaves with a 3-bit frame-type tag and one flag bit, so the encoder downstream knows how to code it. The block runs from a single word clock at twice the reference rate. An internal phase bit marks which of the two word slots in a reference period does the capture. In wide mode both slots carry a word, low half first. In narrow mode only the slot after the capture carries one.

Two framing protocols share the same control pins. In frame mode, a data-valid pin, a control-valid pin and a fill pin pick data, command or one of two idle patterns, and every word carries a flag. In byte mode, the same data-valid and control-valid pins act as transmit-enable and transmit-error, and they pick data, idle, carrier extend or error propagation. A built-in 16-bit counter can replace the input data for link testing. The link controller's state decides whether the block sends real traffic, pure idle, or a one-off word that reports the loss-of-lock count.

Top module: `tx_word_sequencer`

## Requirements
- R1: While rst_n is low (synchronous, active low), word_vld is 0, word_out is 0, word_type is 2 (idle0) and word_flag is 0.
- R2: The word clock runs at twice the reference rate, and the phase starts at 0 on the first edge after reset. A capture happens on edges whose phase equals edge_sel, so edge_sel=0 selects the rising reference edge and edge_sel=1 selects the falling one. The first word produced by a capture appears on the edge of that capture. For data words this is din[15:0]. In wide mode (wide_mode=1) the high word, din[31:16] for data, follows on the next edge. In narrow mode word_vld is 0 on edges that do not capture. Before the first capture, word_vld is 0.
- R3: In frame mode (frame_mode=1), the type of both words in a capture is chosen as follows. sel_ctrl=1 gives type 1 (control), whatever sel_data is. Otherwise sel_data=1 gives type 0 (data). Otherwise fill=0 gives type 2 (idle0) and fill=1 gives type 3 (idle1).
- R4: A control word is {2'b00, half[13:0]}, where half is the 16-bit input half it came from.
- R5: In frame mode with ext_flag_en=1, word_flag is flag_in[0] on the low word and flag_in[1] on the high word. With ext_flag_en=0, word_flag follows an internal bit that starts at 0 after reset and inverts after every emitted word. In byte mode word_flag is 0.
- R6: In byte mode (frame_mode=0), {sel_ctrl,sel_data} selects the type of both words: 00 gives type 2 (idle), 01 gives type 0 (data), 10 gives type 4 (carrier extend) and 11 gives type 5 (error propagation). Carrier extend therefore covers four bytes in wide mode and two bytes in narrow mode.
- R7: With self_test=1 in the ready state, din and the controls are ignored. The words are type 0 and carry a 16-bit counter that starts at 0 after reset and goes up by one per word. In wide mode the pair is n, n+1.
- R8: When link_state is 0 (out of lock) or 1 (locked), every word is type 2 with a value of 0. The inputs are ignored and the self-test counter holds.
- R9: When link_state is 3 (count report), every word carries lol_count zero-extended to 16 bits. Its type is 1 (control) in frame mode and 0 (data) in byte mode.
- R10: Words of type idle0, idle1, carrier extend or error carry the value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, twice the reference rate |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: 32-bit input, two words per period; 0: 16-bit input, one word |
| frame_mode | input | 1 | 1: frame protocol; 0: byte protocol |
| edge_sel | input | 1 | Capture phase: 0 rising reference edge, 1 falling |
| self_test | input | 1 | Use the internal counter as data |
| ext_flag_en | input | 1 | Take flags from flag_in instead of the internal toggle |
| link_state | input | 2 | 0 out of lock, 1 locked, 2 ready, 3 count report |
| lol_count | input | CNT_W | Loss-of-lock count to report |
| din | input | 32 | Input word, low half sent first |
| sel_data | input | 1 | Data valid (frame) / transmit enable (byte) |
| sel_ctrl | input | 1 | Control valid (frame) / transmit error (byte) |
| fill | input | 1 | Idle pattern select in frame mode |
| flag_in | input | 2 | External flags: bit 0 low word, bit 1 high word |
| word_vld | output | 1 | A word is present this cycle |
| word_out | output | 16 | Output word |
| word_type | output | 3 | Frame-type tag |
| word_flag | output | 1 | Flag bit carried with the word |

## Verification
A capture edge registers the low word, so that word can be read at the falling clock edge that follows. In wide mode the high word arrives one word clock later, and the checks look for it there. The bench updates its own model of the phase, the counter and the flag toggle at each falling edge, just after it drives the inputs. It compares against that model one falling edge later, so every expected word is due exactly one register stage after the edge it was built for. The checker adds the two-cycle spacing of the wide pair and the empty slot in narrow mode.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int HALF_W = 16;
  localparam int CMD_W  = 14;

  typedef enum logic [2:0] {
    WT_DATA  = 3'd0,
    WT_CTRL  = 3'd1,
    WT_IDLE0 = 3'd2,
    WT_IDLE1 = 3'd3,
    WT_CEXT  = 3'd4,
    WT_ERR   = 3'd5
  } wtype_e;

  localparam logic [1:0] LS_OFF    = 2'd0;
  localparam logic [1:0] LS_LOCKED = 2'd1;
  localparam logic [1:0] LS_READY  = 2'd2;
  localparam logic [1:0] LS_REPORT = 2'd3;

  // frame type from the shared control pins
  function automatic wtype_e pick_type(input logic frame, input logic s_data,
                                       input logic s_ctrl, input logic fill);
    wtype_e t;
    if (frame) begin
      if (s_ctrl)      t = WT_CTRL;
      else if (s_data) t = WT_DATA;
      else if (fill)   t = WT_IDLE1;
      else             t = WT_IDLE0;
    end else begin
      case ({s_ctrl, s_data})
        2'b01:   t = WT_DATA;
        2'b10:   t = WT_CEXT;
        2'b11:   t = WT_ERR;
        default: t = WT_IDLE0;
      endcase
    end
    return t;
  endfunction

  // word payload for a given type
  function automatic logic [HALF_W-1:0] shape_word(input wtype_e t,
                                                   input logic [HALF_W-1:0] half);
    logic [HALF_W-1:0] w;
    case (t)
      WT_DATA: w = half;
      WT_CTRL: w = {{(HALF_W-CMD_W){1'b0}}, half[CMD_W-1:0]};
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/tws_phase.sv
module tws_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_sel,
  output logic cap_evt
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign cap_evt = rst_n && (phase_q == edge_sel);
endmodule

// File: rtl/tws_selftest.sv
module tws_selftest #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         two_step,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n)   val <= '0;
    else if (adv) val <= val + (two_step ? TWO : ONE);
  end
endmodule

// File: rtl/tws_pair_build.sv
module tws_pair_build
  import tws_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [1:0]          link_state,
  input  logic                frame_mode,
  input  logic                self_test,
  input  logic [2*HALF_W-1:0] din,
  input  logic                sel_data,
  input  logic                sel_ctrl,
  input  logic                fill,
  input  logic [CNT_W-1:0]    lol_count,
  input  logic [HALF_W-1:0]   st_val,
  output logic [HALF_W-1:0]   lo_w,
  output wtype_e              lo_t,
  output logic [HALF_W-1:0]   hi_w,
  output wtype_e              hi_t,
  output logic                st_adv
);
  logic [HALF_W-1:0] cnt_word;
  wtype_e            sel_t;

  assign cnt_word = {{(HALF_W-CNT_W){1'b0}}, lol_count};
  assign sel_t    = pick_type(frame_mode, sel_data, sel_ctrl, fill);

  always_comb begin
    st_adv = 1'b0;
    lo_w   = '0;
    hi_w   = '0;
    lo_t   = WT_IDLE0;
    hi_t   = WT_IDLE0;
    case (link_state)
      LS_REPORT: begin
        lo_w = cnt_word;
        hi_w = cnt_word;
        lo_t = frame_mode ? WT_CTRL : WT_DATA;
        hi_t = lo_t;
      end
      LS_READY: begin
        if (self_test) begin
          st_adv = 1'b1;
          lo_w   = st_val;
          hi_w   = st_val + HALF_W'(1);
          lo_t   = WT_DATA;
          hi_t   = WT_DATA;
        end else begin
          lo_t = sel_t;
          hi_t = sel_t;
          lo_w = shape_word(sel_t, din[HALF_W-1:0]);
          hi_w = shape_word(sel_t, din[2*HALF_W-1:HALF_W]);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tx_word_sequencer.sv
module tx_word_sequencer
  import tws_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_mode,
  input  logic                frame_mode,
  input  logic                edge_sel,
  input  logic                self_test,
  input  logic                ext_flag_en,
  input  logic [1:0]          link_state,
  input  logic [CNT_W-1:0]    lol_count,
  input  logic [2*HALF_W-1:0] din,
  input  logic                sel_data,
  input  logic                sel_ctrl,
  input  logic                fill,
  input  logic [1:0]          flag_in,
  output logic                word_vld,
  output logic [HALF_W-1:0]   word_out,
  output logic [2:0]          word_type,
  output logic                word_flag
);
  logic              cap_evt;
  logic [HALF_W-1:0] st_val;
  logic              st_adv;
  logic [HALF_W-1:0] lo_w, hi_w;
  wtype_e            lo_t, hi_t;

  logic [HALF_W-1:0] hold_w;
  wtype_e            hold_t;
  logic              hold_f;
  logic              tog_q;
  logic              primed_q;
  wtype_e            type_q;

  tws_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_sel (edge_sel),
    .cap_evt  (cap_evt)
  );

  tws_selftest #(.W(HALF_W)) u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (st_adv && cap_evt),
    .two_step (wide_mode),
    .val      (st_val)
  );

  tws_pair_build #(.CNT_W(CNT_W)) u_pair (
    .link_state (link_state),
    .frame_mode (frame_mode),
    .self_test  (self_test),
    .din        (din),
    .sel_data   (sel_data),
    .sel_ctrl   (sel_ctrl),
    .fill       (fill),
    .lol_count  (lol_count),
    .st_val     (st_val),
    .lo_w       (lo_w),
    .lo_t       (lo_t),
    .hi_w       (hi_w),
    .hi_t       (hi_t),
    .st_adv     (st_adv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_vld <= 1'b0;
      word_out <= '0;
      type_q   <= WT_IDLE0;
      word_flag <= 1'b0;
      hold_w   <= '0;
      hold_t   <= WT_IDLE0;
      hold_f   <= 1'b0;
      tog_q    <= 1'b0;
      primed_q <= 1'b0;
    end else if (cap_evt) begin
      word_vld  <= 1'b1;
      word_out  <= lo_w;
      type_q    <= lo_t;
      word_flag <= frame_mode && (ext_flag_en ? flag_in[0] : tog_q);
      tog_q     <= ~tog_q;
      hold_w    <= hi_w;
      hold_t    <= hi_t;
      hold_f    <= flag_in[1];
      primed_q  <= 1'b1;
    end else if (wide_mode && primed_q) begin
      word_vld  <= 1'b1;
      word_out  <= hold_w;
      type_q    <= hold_t;
      word_flag <= frame_mode && (ext_flag_en ? hold_f : tog_q);
      tog_q     <= ~tog_q;
    end else begin
      word_vld <= 1'b0;
    end
  end

  assign word_type = type_q;
endmodule

// File: rtl/tws_checker.sv
module tws_checker
  import tws_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cap_evt,
  input logic        wide_mode,
  input logic        frame_mode,
  input logic [1:0]  link_state,
  input logic        word_vld,
  input logic [15:0] word_out,
  input logic [2:0]  word_type,
  input logic        word_flag
);
  AST_ONE_CAPTURE_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt); // R2
  AST_CAPTURE_YIELDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> word_vld); // R2
  AST_WIDE_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && wide_mode |=> ##1 word_vld); // R2
  AST_NARROW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode && !cap_evt |=> !word_vld); // R2
  AST_NOT_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && !link_state[1] |=> (word_type == 3'(WT_IDLE0) && word_out == 16'd0)); // R8
  AST_CMD_TOP_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && word_type == 3'(WT_CTRL) |-> word_out[15:14] == 2'b00); // R4
  AST_BYTE_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && !frame_mode |-> !word_flag); // R5
  AST_BYTE_NO_IDLE1: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && !frame_mode |-> word_type != 3'(WT_IDLE1)); // R6
  AST_FRAME_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && frame_mode |-> (word_type != 3'(WT_CEXT) && word_type != 3'(WT_ERR))); // R3
endmodule

bind tx_word_sequencer tws_checker i_tws_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_evt    (cap_evt),
  .wide_mode  (wide_mode),
  .frame_mode (frame_mode),
  .link_state (link_state),
  .word_vld   (word_vld),
  .word_out   (word_out),
  .word_type  (word_type),
  .word_flag  (word_flag)
);

// File: tb/test_tx_word_sequencer.sv
module test_tx_word_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_CYCLES = 300;
  localparam logic [2:0] T_DATA = 3'd0, T_CTRL = 3'd1, T_IDLE0 = 3'd2,
                         T_IDLE1 = 3'd3, T_CEXT = 3'd4, T_ERR = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0, frame_mode = 1'b0, edge_sel = 1'b0;
  logic        self_test = 1'b0, ext_flag_en = 1'b0;
  logic [1:0]  link_state = 2'd0;
  logic [7:0]  lol_count = 8'd0;
  logic [31:0] din = 32'd0;
  logic        sel_data = 1'b0, sel_ctrl = 1'b0, fill = 1'b0;
  logic [1:0]  flag_in = 2'd0;
  logic        word_vld;
  logic [15:0] word_out;
  logic [2:0]  word_type;
  logic        word_flag;

  int checks = 0;
  int errors = 0;

  // bench model state
  int          m_k;
  bit          m_primed, m_tog, m_hf;
  logic [15:0] m_cnt, m_hw;
  logic [2:0]  m_ht;
  string       m_hwr, m_htr;
  bit          e_have, e_vld, e_f;
  logic [15:0] e_w;
  logic [2:0]  e_t;
  string       e_wr, e_tr;

  tx_word_sequencer i_tx_word_sequencer (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .frame_mode(frame_mode),
    .edge_sel(edge_sel), .self_test(self_test), .ext_flag_en(ext_flag_en),
    .link_state(link_state), .lol_count(lol_count), .din(din),
    .sel_data(sel_data), .sel_ctrl(sel_ctrl), .fill(fill), .flag_in(flag_in),
    .word_vld(word_vld), .word_out(word_out), .word_type(word_type),
    .word_flag(word_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected word and type for one input half in ready state, normal source
  task automatic half_expect(input logic [15:0] half, output logic [15:0] w,
                             output logic [2:0] t, output string wr, output string tr);
    if (frame_mode) begin
      tr = "R3";
      if (sel_ctrl) begin
        t = T_CTRL; w = half & 16'h3fff; wr = "R4";
      end else if (sel_data) begin
        t = T_DATA; w = half; wr = "R2";
      end else begin
        t = fill ? T_IDLE1 : T_IDLE0; w = 16'd0; wr = "R10";
      end
    end else begin
      tr = "R6";
      w  = 16'd0; wr = "R10";
      if (!sel_ctrl && sel_data) begin
        t = T_DATA; w = half; wr = "R2";
      end else if (!sel_ctrl) t = T_IDLE0;
      else if (!sel_data)     t = T_CEXT;
      else                    t = T_ERR;
    end
  endtask

  task automatic build_expect();
    logic [15:0] lw, hw;
    logic [2:0]  lt, ht;
    string       lwr, ltr, hwr, htr;
    bit          cap;
    cap = ((m_k % 2) == int'(edge_sel));
    if (cap) begin
      if (link_state == 2'd0 || link_state == 2'd1) begin
        lw = 16'd0; hw = 16'd0; lt = T_IDLE0; ht = T_IDLE0;
        lwr = "R8"; ltr = "R8"; hwr = "R8"; htr = "R8";
      end else if (link_state == 2'd3) begin
        lw = {8'd0, lol_count}; hw = lw; lt = frame_mode ? T_CTRL : T_DATA; ht = lt;
        lwr = "R9"; ltr = "R9"; hwr = "R9"; htr = "R9";
      end else if (self_test) begin
        lw = m_cnt; hw = m_cnt + 16'd1; lt = T_DATA; ht = T_DATA;
        m_cnt = m_cnt + (wide_mode ? 16'd2 : 16'd1);
        lwr = "R7"; ltr = "R7"; hwr = "R7"; htr = "R7";
      end else begin
        half_expect(din[15:0], lw, lt, lwr, ltr);
        half_expect(din[31:16], hw, ht, hwr, htr);
      end
      e_vld = 1'b1; e_w = lw; e_t = lt; e_wr = lwr; e_tr = ltr;
      e_f = frame_mode && (ext_flag_en ? flag_in[0] : m_tog);
      m_tog = ~m_tog;
      m_hw = hw; m_ht = ht; m_hwr = hwr; m_htr = htr; m_hf = flag_in[1];
      m_primed = 1'b1;
    end else if (wide_mode && m_primed) begin
      e_vld = 1'b1; e_w = m_hw; e_t = m_ht; e_wr = m_hwr; e_tr = m_htr;
      e_f = frame_mode && (ext_flag_en ? m_hf : m_tog);
      m_tog = ~m_tog;
    end else begin
      e_vld = 1'b0;
    end
    m_k++;
    e_have = 1'b1;
  endtask

  task automatic compare();
    chk(word_vld == e_vld, "R2", "word_vld", 32'(word_vld), 32'(e_vld));
    if (e_vld && word_vld) begin
      chk(word_type == e_t, e_tr, "word_type", 32'(word_type), 32'(e_t));
      chk(word_out == e_w, e_wr, "word_out", 32'(word_out), 32'(e_w));
      chk(word_flag == e_f, "R5", "word_flag", 32'(word_flag), 32'(e_f));
    end
  endtask

  task automatic drive_random();
    int r;
    r = $urandom_range(0, 9);
    link_state = (r < 7) ? 2'd2 : (r == 7) ? 2'd0 : (r == 8) ? 2'd1 : 2'd3;
    din = $urandom;
    sel_data = 1'($urandom); sel_ctrl = 1'($urandom); fill = 1'($urandom);
    flag_in = 2'($urandom); lol_count = 8'($urandom);
  endtask

  task automatic run_segment(input bit w, input bit f, input bit es, input bit st,
                             input bit ef);
    @(negedge clk);
    rst_n = 1'b0;
    wide_mode = w; frame_mode = f; edge_sel = es; self_test = st; ext_flag_en = ef;
    drive_random();
    repeat (3) @(negedge clk);
    chk(word_vld == 1'b0, "R1", "reset word_vld", 32'(word_vld), 32'd0);
    chk(word_out == 16'd0, "R1", "reset word_out", 32'(word_out), 32'd0);
    chk(word_type == T_IDLE0, "R1", "reset word_type", 32'(word_type), 32'(T_IDLE0));
    chk(word_flag == 1'b0, "R1", "reset word_flag", 32'(word_flag), 32'd0);
    rst_n = 1'b1;
    m_k = 0; m_primed = 1'b0; m_tog = 1'b0; m_cnt = 16'd0;
    m_hw = 16'd0; m_ht = T_IDLE0; m_hf = 1'b0; e_have = 1'b0;
    drive_random();
    build_expect();
    for (int i = 0; i < SEG_CYCLES; i++) begin
      @(negedge clk);
      compare();
      drive_random();
      build_expect();
    end
    @(negedge clk);
    compare();
  endtask

  task automatic directed_not_ready();
    // R8: inputs and self-test ignored while not ready, counter held
    @(negedge clk);
    rst_n = 1'b0;
    wide_mode = 1'b1; frame_mode = 1'b1; edge_sel = 1'b0; self_test = 1'b1; ext_flag_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_k = 0; m_primed = 1'b0; m_tog = 1'b0; m_cnt = 16'd0;
    m_hw = 16'd0; m_ht = T_IDLE0; m_hf = 1'b0;
    for (int i = 0; i < 40; i++) begin
      link_state = (i < 20) ? 2'd1 : 2'd2;
      din = 32'hffff_ffff; sel_data = 1'b1; sel_ctrl = 1'b1;
      build_expect();
      @(negedge clk);
      compare();
    end
    chk(m_cnt == 16'd20, "R7", "bench counter span", 32'(m_cnt), 32'd20);
  endtask

  initial begin
    void'($urandom(32'd4242));
    directed_not_ready();
    for (int c = 0; c < 8; c++) begin
      run_segment(c[0], c[1], c[2], 1'b0, 1'($urandom));
      run_segment(c[0], c[1], c[2], 1'b1, 1'($urandom));
      run_segment(c[0], c[1], c[2], 1'($urandom), 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule